// File: doc/BRIEF.md
# PLL Serial Control Register Interface

This block is the digital control front end of a frequency synthesizer. A host processor writes it over a three-wire serial bus made of a bit clock, a data line and a frame enable. Each frame carries an 8-bit word. Its two most significant bits pick one of four 6-bit control registers, and the remaining six bits are the new register contents. A frame of any other length is dropped without touching any register.

The register contents configure the synthesizer. Two bits choose the charge-pump current magnitude, and one bit picks which of two loop-filter inputs is active. A 3-bit test code chooses what appears on the test-output pin and how the oscillator pin is used. In normal application mode the test pin carries the application output and the oscillator pin feeds the oscillator. One test code instead puts the synthesized-frequency divider output on the test pin and turns the oscillator pin into an external reference input.

The bus lines are asynchronous to the system clock. They pass through two-flop synchronizers, and bus edges are detected in the system clock domain. A register write is applied as a single-cycle, whole-word update.

Top module: `pll_ctl_serial`

## Requirements
- R1: While the enable is high, data is shifted in on each rising bus-clock edge, MSB first. When the enable falls after exactly 8 shifted bits, the word is written: bits [7:6] are the address and bits [5:0] are the data.
- R2: A frame with fewer than 8 bits writes no register.
- R3: A frame with more than 8 bits writes no register.
- R4: Address 00 writes register 0, 01 writes register 1, 10 writes register 2 and 11 writes register 3. The other three registers keep their values. On `reg_bank_o`, register n appears at bits [6n+5:6n].
- R5: After reset all four registers are zero. The block is therefore in application-mode routing, with current select 00 and filter select 0.
- R6: `cur_sel_o` equals register 0 bits [1:0]. Bit 0 is the first current bit and bit 1 is the second.
- R7: `filt_sel_o` equals register 0 bit 2. A value of 0 selects the first filter input and 1 selects the second.
- R8: The test code is register 3 bits [2:0]. With code 000: `test_pin_o` = `app_out_i`, `osc_core_o` = `osc_pad_i`, and `fref_ext_o` = 0.
- R9: With test code 110: `test_pin_o` = `fsyn_div_i`, `fref_ext_o` = `osc_pad_i`, and `osc_core_o` = 0.
- R10: Every test code other than 000 and 110 routes exactly as code 000.
- R11: A bus-clock rising edge that is detected in the same system cycle as the enable fall is not shifted in. A frame of 8 bits followed by such an edge is still accepted.
- R12: A write is visible on the outputs no later than the sixth rising system-clock edge after the enable falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_clk | input | 1 | Serial bit clock from host (asynchronous) |
| bus_dat | input | 1 | Serial data from host (asynchronous) |
| bus_en | input | 1 | Frame enable from host (asynchronous) |
| app_out_i | input | 1 | Application-mode signal for the test pin |
| fsyn_div_i | input | 1 | Synthesized-frequency divider output |
| osc_pad_i | input | 1 | Signal arriving on the oscillator pin |
| reg_bank_o | output | 24 | All four registers, register n at [6n+5:6n] |
| cur_sel_o | output | 2 | Charge-pump current select |
| filt_sel_o | output | 1 | Loop-filter input select |
| test_pin_o | output | 1 | Test-output pin drive |
| osc_core_o | output | 1 | Oscillator pin routed to the oscillator |
| fref_ext_o | output | 1 | Oscillator pin routed as the reference input |

## Verification
The two events that can fall in the same system cycle are the last bus-clock rising edge and the enable fall. Both travel through synchronizers of identical depth, so they can be detected on the same cycle. The bench provokes this by switching the bus clock high and the enable low in the same time step, directly after an 8-bit frame. It judges the result by the register contents: the frame must be written with its 8 bits, because counting the coincident edge would make a 9-bit frame, which is rejected. Random frames of 6 to 9 bits, with random addresses and data, run alongside this and are compared against a bench model of the register file and of the routing.

// File: rtl/pllctl_pkg.sv
package pllctl_pkg;

    localparam int REG_W      = 6;
    localparam int NUM_REGS   = 4;
    localparam int ADDR_W     = $clog2(NUM_REGS);
    localparam int FRAME_BITS = ADDR_W + REG_W;
    localparam int CODE_W     = 3;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [REG_W-1:0]  word_t;
    typedef logic [CODE_W-1:0] code_t;

    typedef struct packed {
        addr_t addr;
        word_t data;
    } wr_req_t;

    typedef struct packed {
        logic       lpf;
        logic [1:0] cur;
    } pll_cfg_t;

    typedef enum logic {
        ROUTE_APP = 1'b0,
        ROUTE_SYN = 1'b1
    } route_e;

    localparam code_t TC_APP = 3'b000;
    localparam code_t TC_SYN = 3'b110;

    localparam int CFG_REG  = 0;
    localparam int TEST_REG = 3;

    function automatic route_e decode_route(input code_t c);
        return (c == TC_SYN) ? ROUTE_SYN : ROUTE_APP;
    endfunction

    function automatic pll_cfg_t unpack_cfg(input word_t w);
        pll_cfg_t r;
        r.cur = w[1:0];
        r.lpf = w[2];
        return r;
    endfunction

endpackage

// File: rtl/pllctl_sync.sv
module pllctl_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q,
    output logic [W-1:0] q_prev
);
    logic [W-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stage_q[0] <= '0;
        else     stage_q[0] <= d;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stage_q[s] <= '0;
            else     stage_q[s] <= stage_q[s-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q_prev <= '0;
        else     q_prev <= stage_q[STAGES-1];
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/pllctl_rx.sv
module pllctl_rx
    import pllctl_pkg::*;
#(
    parameter int NBITS = FRAME_BITS
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    sck_s,
    input  logic    sck_p,
    input  logic    sdi_s,
    input  logic    sen_s,
    input  logic    sen_p,
    output logic    wr_valid,
    output wr_req_t wr_q
);
    localparam int CNT_MAX = NBITS + 1;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    logic [CNT_W-1:0] cnt_q;
    logic [NBITS-1:0] sh_q;
    logic             sck_rise, en_rise, en_fall;

    assign sck_rise = sck_s & ~sck_p;
    assign en_rise  = sen_s & ~sen_p;
    assign en_fall  = ~sen_s & sen_p;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q    <= '0;
            sh_q     <= '0;
            wr_valid <= 1'b0;
            wr_q     <= '0;
        end else begin
            wr_valid <= 1'b0;
            if (en_rise) begin
                cnt_q <= '0;
            end else if (en_fall) begin
                if (cnt_q == CNT_W'(NBITS)) begin
                    wr_valid <= 1'b1;
                    wr_q     <= wr_req_t'(sh_q);
                end
                cnt_q <= '0;
            end else if (sen_s && sck_rise) begin
                sh_q <= {sh_q[NBITS-2:0], sdi_s};
                if (cnt_q != CNT_W'(CNT_MAX)) cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    p_one_pulse_r1: assert property (@(posedge clk) disable iff (rst)
        wr_valid |=> !wr_valid);
    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_W'(CNT_MAX));
    p_cnt_clear_r2: assert property (@(posedge clk) disable iff (rst)
        en_rise |=> (cnt_q == '0));
endmodule

// File: rtl/pllctl_regfile.sv
module pllctl_regfile
    import pllctl_pkg::*;
#(
    parameter int NREG = NUM_REGS
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_valid,
    input  wr_req_t                    wr_q,
    output logic [NREG-1:0][REG_W-1:0] bank_q
);
    for (genvar i = 0; i < NREG; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                bank_q[i] <= '0;
            else if (wr_valid && (wr_q.addr == addr_t'(i)))
                bank_q[i] <= wr_q.data;
        end
    end

    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !wr_valid |=> $stable(bank_q));
    p_write_r4: assert property (@(posedge clk) disable iff (rst)
        wr_valid |=> (bank_q[$past(wr_q.addr)] == $past(wr_q.data)));
endmodule

// File: rtl/pllctl_router.sv
module pllctl_router
    import pllctl_pkg::*;
(
    input  code_t code,
    input  logic  app_out,
    input  logic  fsyn_div,
    input  logic  osc_pad,
    output logic  test_pin,
    output logic  osc_core,
    output logic  fref_ext
);
    route_e mode;

    always_comb begin
        mode = decode_route(code);
        unique case (mode)
            ROUTE_SYN: begin
                test_pin = fsyn_div;
                osc_core = 1'b0;
                fref_ext = osc_pad;
            end
            default: begin
                test_pin = app_out;
                osc_core = osc_pad;
                fref_ext = 1'b0;
            end
        endcase
    end

    always_comb begin
        if (code != TC_SYN) p_app_fallback_r10: assert (fref_ext == 1'b0);
        p_exclusive_r9: assert (!(osc_core && fref_ext));
    end
endmodule

// File: rtl/pll_ctl_serial.sv
module pll_ctl_serial
    import pllctl_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           bus_clk,
    input  logic                           bus_dat,
    input  logic                           bus_en,
    input  logic                           app_out_i,
    input  logic                           fsyn_div_i,
    input  logic                           osc_pad_i,
    output logic [NUM_REGS*REG_W-1:0]      reg_bank_o,
    output logic [1:0]                     cur_sel_o,
    output logic                           filt_sel_o,
    output logic                           test_pin_o,
    output logic                           osc_core_o,
    output logic                           fref_ext_o
);
    logic [2:0] bus_s, bus_p;
    logic       wr_valid;
    wr_req_t    wr_q;
    logic [NUM_REGS-1:0][REG_W-1:0] bank;
    pll_cfg_t   cfg;

    pllctl_sync #(.W(3), .STAGES(2)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .d      ({bus_en, bus_dat, bus_clk}),
        .q      (bus_s),
        .q_prev (bus_p)
    );

    pllctl_rx #(.NBITS(FRAME_BITS)) u_rx (
        .clk      (clk),
        .rst      (rst),
        .sck_s    (bus_s[0]),
        .sck_p    (bus_p[0]),
        .sdi_s    (bus_s[1]),
        .sen_s    (bus_s[2]),
        .sen_p    (bus_p[2]),
        .wr_valid (wr_valid),
        .wr_q     (wr_q)
    );

    pllctl_regfile #(.NREG(NUM_REGS)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_valid (wr_valid),
        .wr_q     (wr_q),
        .bank_q   (bank)
    );

    assign cfg        = unpack_cfg(bank[CFG_REG]);
    assign cur_sel_o  = cfg.cur;
    assign filt_sel_o = cfg.lpf;
    assign reg_bank_o = bank;

    pllctl_router u_route (
        .code     (bank[TEST_REG][CODE_W-1:0]),
        .app_out  (app_out_i),
        .fsyn_div (fsyn_div_i),
        .osc_pad  (osc_pad_i),
        .test_pin (test_pin_o),
        .osc_core (osc_core_o),
        .fref_ext (fref_ext_o)
    );

    p_reset_zero_r5: assert property (@(posedge clk)
        $past(rst) |-> (reg_bank_o == '0));
endmodule

// File: tb/test_pll_ctl_serial.sv
module test_pll_ctl_serial;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bus_clk = 1'b0, bus_dat = 1'b0, bus_en = 1'b0;
    logic app_out_i = 1'b0, fsyn_div_i = 1'b0, osc_pad_i = 1'b0;
    logic [23:0] reg_bank_o;
    logic [1:0]  cur_sel_o;
    logic        filt_sel_o, test_pin_o, osc_core_o, fref_ext_o;

    int total = 0;
    int bad   = 0;
    logic [5:0] model [4];

    always #5 clk = ~clk;

    pll_ctl_serial i_pll_ctl_serial (
        .clk(clk), .rst(rst), .bus_clk(bus_clk), .bus_dat(bus_dat), .bus_en(bus_en),
        .app_out_i(app_out_i), .fsyn_div_i(fsyn_div_i), .osc_pad_i(osc_pad_i),
        .reg_bank_o(reg_bank_o), .cur_sel_o(cur_sel_o), .filt_sel_o(filt_sel_o),
        .test_pin_o(test_pin_o), .osc_core_o(osc_core_o), .fref_ext_o(fref_ext_o)
    );

    function automatic logic [23:0] exp_bank();
        return {model[3], model[2], model[1], model[0]};
    endfunction

    function automatic logic [2:0] exp_route(input logic [2:0] code, input logic app,
                                             input logic fsyn, input logic osc);
        if (code == 3'b110) return {fsyn, 1'b0, osc};
        return {app, osc, 1'b0};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic shift_bits(input int nbits, input logic [15:0] val);
        for (int i = nbits - 1; i >= 0; i--) begin
            bus_dat = val[i];
            wait_clk(3);
            bus_clk = 1'b1;
            wait_clk(3);
            bus_clk = 1'b0;
        end
    endtask

    task automatic send_frame(input int nbits, input logic [15:0] val);
        bus_en = 1'b1;
        wait_clk(4);
        shift_bits(nbits, val);
        wait_clk(3);
        bus_en = 1'b0;
        wait_clk(6);
        if (nbits == 8) model[val[7:6]] = val[5:0];
    endtask

    task automatic check_outputs(input string tag);
        logic [2:0] er;
        check({tag, " bank R1 R4"}, 32'(reg_bank_o), 32'(exp_bank()));
        check({tag, " cur R6"}, 32'(cur_sel_o), 32'(model[0][1:0]));
        check({tag, " filt R7"}, 32'(filt_sel_o), 32'(model[0][2]));
        for (int k = 0; k < 4; k++) begin
            app_out_i  = k[0];
            fsyn_div_i = k[1];
            osc_pad_i  = k[0] ^ k[1];
            #1;
            er = exp_route(model[3][2:0], app_out_i, fsyn_div_i, osc_pad_i);
            check({tag, " route R8 R9 R10"}, 32'({test_pin_o, osc_core_o, fref_ext_o}), 32'(er));
        end
    endtask

    initial begin
        #1_000_000;
        bad++;
        total++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        for (int i = 0; i < 4; i++) model[i] = '0;
        wait_clk(4);
        rst = 1'b0;
        wait_clk(2);
        check_outputs("reset R5");

        // R1 R4: directed write to each address
        for (int a = 0; a < 4; a++) begin
            send_frame(8, 16'({a[1:0], 6'(6'h15 + a)}));
            check_outputs("directed addr R4");
        end
        // R9: test code 110 into register 3
        send_frame(8, 16'({2'b11, 6'b000110}));
        check_outputs("code110 R9");
        // R10: reserved code 101
        send_frame(8, 16'({2'b11, 6'b000101}));
        check_outputs("code101 R10");
        // R2: 7-bit frame ignored
        send_frame(7, 16'h7F);
        check_outputs("short R2");
        // R3: 9-bit frame ignored
        send_frame(9, 16'h1FF);
        check_outputs("long R3");

        // R11: last clock edge switches with the enable fall
        bus_en = 1'b1;
        wait_clk(4);
        shift_bits(8, 16'({2'b00, 6'b101011}));
        wait_clk(3);
        bus_clk = 1'b1;
        bus_en  = 1'b0;
        wait_clk(3);
        bus_clk = 1'b0;
        wait_clk(4);
        model[0] = 6'b101011;
        check_outputs("coincident R11");

        // R12: latency bound after enable fall
        bus_en = 1'b1;
        wait_clk(4);
        shift_bits(8, 16'({2'b01, 6'b110011}));
        wait_clk(3);
        bus_en = 1'b0;
        wait_clk(6);
        model[1] = 6'b110011;
        check("latency R12", 32'(reg_bank_o[11:6]), 32'(model[1]));

        // random mix of frame lengths
        for (int n = 0; n < 50; n++) begin
            int len;
            logic [15:0] v;
            len = 6 + int'($urandom_range(0, 3));
            v   = 16'($urandom);
            if (($urandom_range(0, 3) == 0) && len == 8) v[7:6] = 2'b11;
            send_frame(len, v);
            check_outputs("random R1 R2 R3");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule